// File: doc/BRIEF.md
# Four-Channel DMA Address and Count Core

This block holds the programming state and the address/count arithmetic of a four-channel DMA controller. A host reaches it through a byte-wide, port-addressed register interface. Each channel keeps a 16-bit base and current address, a 16-bit base and current count, an 8-bit page value and a mode setting. The 16-bit registers are loaded and read one byte at a time. A single shared byte pointer alternates between the low byte and the high byte, and a control write resets that pointer to the low byte.

When a channel's transfer-step input pulses and the channel is enabled, its address moves by one and its count drops by one. The count holds the number of transfers minus one, so terminal count arrives on the step taken while the count is zero. The block then flags the channel in its status register. It either reloads the channel from the base values or masks the channel. Bus arbitration and the memory or I/O cycles themselves happen outside this block. The effective address is the page byte placed above the 16-bit current address.

Top module: `dmac4_core`

## Requirements
- R1: After reset all four channel masks are set, the byte pointer selects the low byte, status reads 0x00 (with no request input), and every address and count register reads 0x0000.
- R2: Channel n's address register sits at port offset 2n and its count register at 2n+1. Each read or write of these ports toggles the shared byte pointer, low byte first. A write to offset 0x0C returns the pointer to the low byte. A write loads both the base and the current value.
- R3: A write to the mode register at offset 0x0B selects the channel with bits [1:0]. Bit 4 enables auto-initialisation, bit 5 selects address decrement, and bits [7:6] = 11 select cascade, which the cascade output shows.
- R4: A write to offset 0x0A sets the mask of the channel in bits [1:0] to bit 2. A write to 0x0E clears all masks. A write to 0x0F loads all masks from bits [3:0]. The chan_mask output shows the masks.
- R5: A step on an enabled channel whose count is not zero lowers the count by one and moves the address by one, upward unless decrement is selected.
- R6: A step on an enabled channel whose count is zero is terminal count. tc_pulse shows it in that cycle, the count wraps to 0xFFFF, and the channel's status bit [n] is set. Without auto-initialisation the address still moves and the channel becomes masked.
- R7: At terminal count with auto-initialisation on, the current address and count reload from the base values and the channel stays unmasked.
- R8: A read of offset 0x08 returns terminal-count flags in bits [3:0] and requests in bits [7:4]. A request is the dreq input OR'd with the software request. The read clears bits [3:0], but a terminal count in the same cycle keeps its flag.
- R9: A write to offset 0x09 sets (bit 2 = 1) or clears (bit 2 = 0) the software request of the channel in bits [1:0]. A channel's terminal count clears its software request.
- R10: A step is ignored on a masked channel, on a channel in cascade mode, and while command bit 2 (written at offset 0x08) is set.
- R11: A write to offset 0x0D resets the byte pointer, the command bit, the status flags and the software requests, and sets all masks. A read of 0x0D returns 0x00.
- R12: Pulsing pg_wr writes bus_wdata into the page of channel pg_sel. eff_addr slice n is {page, current address}. A 16-bit address wrap leaves the page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register port offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| pg_wr | input | 1 | Page register write strobe |
| pg_sel | input | 2 | Channel for the page write |
| dreq | input | 4 | Hardware request lines, shown in status |
| step | input | 4 | Per-channel transfer-step pulses |
| tc_pulse | output | 4 | Terminal count, in the cycle of the final step |
| cascade | output | 4 | Channel is in cascade mode |
| chan_mask | output | 4 | Channel mask bits |
| eff_addr | output | 96 | Per-channel {page, address}, channel n at bits [24n+23:24n] |

## Verification
The assertions check on every cycle that terminal count sets its status flag. They also check that terminal count masks a channel without auto-initialisation and leaves an auto-initialising channel open. Further per-cycle checks cover the count dropping by exactly one on a normal step, blocked steps leaving the count untouched, master clear setting every mask, and the page byte holding still unless written. Other behaviour can only be shown by the bench's scenarios, which compare port reads against bench-computed values. This covers the byte-pointer order and its reset, the reload values after auto-initialisation, decrement mode, the page staying fixed across a 64 KiB wrap, and the clear-on-read of the status flags.

// File: rtl/dmac4_pkg.sv
// Package: port offsets of the control registers and the decoded per-channel
// mode. Assumes a 4-bit port offset space (channel ports below 0x08).
package dmac4_pkg;

    localparam logic [3:0] OFS_CMD    = 4'h8;  // command write / status read
    localparam logic [3:0] OFS_REQ    = 4'h9;  // software request
    localparam logic [3:0] OFS_MASK1  = 4'hA;  // one-channel mask
    localparam logic [3:0] OFS_MODE   = 4'hB;  // mode byte
    localparam logic [3:0] OFS_CLRPTR = 4'hC;  // byte pointer to low
    localparam logic [3:0] OFS_MCLR   = 4'hD;  // master clear
    localparam logic [3:0] OFS_UNMASK = 4'hE;  // clear every mask
    localparam logic [3:0] OFS_MASKN  = 4'hF;  // load every mask

    typedef struct packed {
        logic autoinit;
        logic decr;
        logic casc;
    } chan_mode_t;

    // Decode the upper mode-byte fields that steer the counters.
    function automatic chan_mode_t mode_decode(input logic [7:0] b);
        chan_mode_t m;
        m.autoinit = b[4];
        m.decr     = b[5];
        m.casc     = (b[7:6] == 2'b11);
        return m;
    endfunction

endpackage

// File: rtl/dmac4_chan.sv
// Module: one DMA channel. It holds the base/current address and count, the
// page byte and the mode, and performs a step when step_ok is high.
// Assumes the register width is exactly two bytes and that the bus write wins
// over a step that arrives in the same cycle.
module dmac4_chan
    import dmac4_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          mode_wr,
    input  logic          page_wr,
    input  logic          hi,
    input  logic [DW-1:0] wdata,
    input  logic          step_ok,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output logic          autoinit,
    output logic          cascade,
    output logic          tc_evt
);
    localparam int HB = AW - DW;

    logic [AW-1:0] base_addr, base_cnt;
    chan_mode_t    mode_q;

    assign tc_evt   = step_ok && (cur_cnt == '0);
    assign autoinit = mode_q.autoinit;
    assign cascade  = mode_q.casc;

    // Address registers: byte loads from the bus, or step/reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            if (hi) begin
                base_addr[AW-1:DW] <= wdata[HB-1:0];
                cur_addr[AW-1:DW]  <= wdata[HB-1:0];
            end else begin
                base_addr[DW-1:0] <= wdata;
                cur_addr[DW-1:0]  <= wdata;
            end
        end else if (step_ok) begin
            if (tc_evt && mode_q.autoinit) cur_addr <= base_addr;
            else if (mode_q.decr)          cur_addr <= cur_addr - 1'b1;
            else                           cur_addr <= cur_addr + 1'b1;
        end
    end

    // Count registers: byte loads from the bus, or decrement/reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            if (hi) begin
                base_cnt[AW-1:DW] <= wdata[HB-1:0];
                cur_cnt[AW-1:DW]  <= wdata[HB-1:0];
            end else begin
                base_cnt[DW-1:0] <= wdata;
                cur_cnt[DW-1:0]  <= wdata;
            end
        end else if (step_ok) begin
            if (tc_evt && mode_q.autoinit) cur_cnt <= base_cnt;
            else                           cur_cnt <= cur_cnt - 1'b1;
        end
    end

    // Mode and page registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            page   <= '0;
        end else begin
            if (mode_wr) mode_q <= mode_decode(wdata);
            if (page_wr) page   <= wdata[PW-1:0];
        end
    end

endmodule

// File: rtl/dmac4_regif.sv
// Module: control side of the core. It decodes the bus, keeps the shared byte
// pointer, the masks, the command disable bit, the terminal-count flags and the
// software requests, and muxes read data. Assumes bus_wr and bus_rd are never
// high together.
module dmac4_regif
    import dmac4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        ctl_wd,
    input  logic [NCH-1:0]    dreq,
    input  logic [NCH-1:0]    tc_evt,
    input  logic [NCH-1:0]    autoinit,
    input  logic [NCH*AW-1:0] addr_flat,
    input  logic [NCH*AW-1:0] cnt_flat,
    output logic              hi,
    output logic [NCH-1:0]    wr_addr,
    output logic [NCH-1:0]    wr_cnt,
    output logic [NCH-1:0]    mode_wr,
    output logic [NCH-1:0]    mask_q,
    output logic [NCH-1:0]    tc_q,
    output logic              ctrl_off,
    output logic [DW-1:0]     rdata
);
    localparam int CHW = $clog2(NCH);

    logic           port_hit;
    logic [CHW-1:0] port_ch;
    logic [CHW-1:0] wd_ch;
    logic           mclr;
    logic [NCH-1:0] soft_q, mask_nx, soft_nx, tc_nx;
    logic [AW-1:0]  word;

    assign port_hit = !bus_addr[3];
    assign port_ch  = bus_addr[CHW:1];
    assign wd_ch    = ctl_wd[CHW-1:0];
    assign mclr     = bus_wr && (bus_addr == OFS_MCLR);

    // Per-channel write strobes for the data ports and the mode register.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            wr_addr[i] = bus_wr && port_hit && (port_ch == CHW'(i)) && !bus_addr[0];
            wr_cnt[i]  = bus_wr && port_hit && (port_ch == CHW'(i)) &&  bus_addr[0];
            mode_wr[i] = bus_wr && (bus_addr == OFS_MODE) && (wd_ch == CHW'(i));
        end
    end

    // Byte pointer: cleared by its own write or master clear, toggled on port access.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                    hi <= 1'b0;
        else if (bus_wr && (bus_addr == OFS_CLRPTR || bus_addr == OFS_MCLR)) hi <= 1'b0;
        else if ((bus_wr || bus_rd) && port_hit)                       hi <= ~hi;
    end

    // Next masks, software requests and flags from bus writes and terminal counts.
    always_comb begin
        mask_nx = mask_q;
        soft_nx = soft_q;
        tc_nx   = (bus_rd && bus_addr == OFS_CMD) ? '0 : tc_q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_MASK1:  mask_nx[wd_ch] = ctl_wd[2];
                OFS_UNMASK: mask_nx = '0;
                OFS_MASKN:  mask_nx = ctl_wd[NCH-1:0];
                OFS_REQ:    soft_nx[wd_ch] = ctl_wd[2];
                OFS_MCLR: begin
                    mask_nx = '1;
                    soft_nx = '0;
                    tc_nx   = '0;
                end
                default: ;
            endcase
        end
        mask_nx = mask_nx | (tc_evt & ~autoinit);
        soft_nx = soft_nx & ~tc_evt;
        tc_nx   = tc_nx | tc_evt;
    end

    // Control state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '1;
            soft_q   <= '0;
            tc_q     <= '0;
            ctrl_off <= 1'b0;
        end else begin
            mask_q <= mask_nx;
            soft_q <= soft_nx;
            tc_q   <= tc_nx;
            if (mclr)                                 ctrl_off <= 1'b0;
            else if (bus_wr && bus_addr == OFS_CMD)   ctrl_off <= ctl_wd[2];
        end
    end

    // Read data: selected channel byte, status, or zero.
    always_comb begin
        word = bus_addr[0] ? cnt_flat[port_ch*AW +: AW] : addr_flat[port_ch*AW +: AW];
        rdata = '0;
        if (bus_rd) begin
            if (port_hit)                   rdata = hi ? word[AW-1:DW] : word[DW-1:0];
            else if (bus_addr == OFS_CMD)   rdata = {dreq | soft_q, tc_q};
        end
    end

endmodule

// File: rtl/dmac4_core.sv
// Module: top of the four-channel DMA address/count core. It ties the control
// block to one counter slice per channel and forms the gated step enables and
// the {page, address} outputs. Assumes four channels, 16-bit registers and a
// byte bus.
module dmac4_core #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    parameter int DW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic                  pg_wr,
    input  logic [$clog2(NCH)-1:0] pg_sel,
    input  logic [NCH-1:0]        dreq,
    input  logic [NCH-1:0]        step,
    output logic [NCH-1:0]        tc_pulse,
    output logic [NCH-1:0]        cascade,
    output logic [NCH-1:0]        chan_mask,
    output logic [NCH*(PW+AW)-1:0] eff_addr
);
    localparam int CHW = $clog2(NCH);
    localparam int EW  = PW + AW;

    logic              hi, ctrl_off;
    logic [NCH-1:0]    wr_addr, wr_cnt, mode_wr, mask_q, tc_q;
    logic [NCH-1:0]    tc_evt, auto_v, step_ok;
    logic [NCH*AW-1:0] addr_flat, cnt_flat;
    logic [NCH*PW-1:0] page_flat;

    dmac4_regif #(.NCH(NCH), .AW(AW), .DW(DW)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .ctl_wd(bus_wdata[3:0]), .dreq(dreq),
        .tc_evt(tc_evt), .autoinit(auto_v),
        .addr_flat(addr_flat), .cnt_flat(cnt_flat),
        .hi(hi), .wr_addr(wr_addr), .wr_cnt(wr_cnt), .mode_wr(mode_wr),
        .mask_q(mask_q), .tc_q(tc_q), .ctrl_off(ctrl_off), .rdata(bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Step enable: channel open, not cascading, controller running.
        assign step_ok[i] = step[i] && !mask_q[i] && !cascade[i] && !ctrl_off;

        dmac4_chan #(.AW(AW), .DW(DW), .PW(PW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_addr(wr_addr[i]), .wr_cnt(wr_cnt[i]), .mode_wr(mode_wr[i]),
            .page_wr(pg_wr && (pg_sel == CHW'(i))),
            .hi(hi), .wdata(bus_wdata), .step_ok(step_ok[i]),
            .cur_addr(addr_flat[i*AW +: AW]), .cur_cnt(cnt_flat[i*AW +: AW]),
            .page(page_flat[i*PW +: PW]),
            .autoinit(auto_v[i]), .cascade(cascade[i]), .tc_evt(tc_evt[i])
        );

        assign eff_addr[i*EW +: EW] = {page_flat[i*PW +: PW], addr_flat[i*AW +: AW]};
    end

    assign tc_pulse  = tc_evt;
    assign chan_mask = mask_q;

endmodule

// File: rtl/dmac4_checker.sv
// Module: cycle-level properties of dmac4_core, attached through bind.
// Assumes bus_wr/bus_rd exclusivity as the core does.
module dmac4_checker #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic [3:0]             bus_addr,
    input logic                   pg_wr,
    input logic [NCH-1:0]         step,
    input logic [NCH-1:0]         step_ok,
    input logic [NCH-1:0]         tc_evt,
    input logic [NCH-1:0]         auto_v,
    input logic [NCH-1:0]         mask_q,
    input logic [NCH-1:0]         tc_q,
    input logic [NCH*AW-1:0]      cnt_flat,
    input logic [NCH*(PW+AW)-1:0] eff_addr
);
    localparam int EW = PW + AW;

    // Master clear closes every channel (R11).
    p_mclr_masks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hD) |=> (mask_q == '1));

    for (genvar i = 0; i < NCH; i++) begin : g_p
        // Terminal count raises its status flag (R6).
        p_tc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tc_evt[i] |=> tc_q[i]);
        // Terminal count without reload closes the channel (R6).
        p_tc_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_evt[i] && !auto_v[i]) |=> mask_q[i]);
        // Reload keeps the channel open (R7).
        p_auto_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_evt[i] && auto_v[i] && !bus_wr) |=> !mask_q[i]);
        // A normal step lowers the count by one (R5).
        p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (step_ok[i] && !bus_wr && cnt_flat[i*AW +: AW] != '0)
            |=> (cnt_flat[i*AW +: AW] == $past(cnt_flat[i*AW +: AW]) - 1'b1));
        // A blocked step leaves the count alone (R10).
        p_blocked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (step[i] && !step_ok[i] && !bus_wr) |=> $stable(cnt_flat[i*AW +: AW]));
        // Page byte moves only on a page write (R12).
        p_page_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !pg_wr |=> $stable(eff_addr[i*EW+AW +: PW]));
    end

endmodule

bind dmac4_core dmac4_checker #(.NCH(NCH), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .pg_wr(pg_wr), .step(step), .step_ok(step_ok), .tc_evt(tc_evt),
    .auto_v(auto_v), .mask_q(mask_q), .tc_q(tc_q), .cnt_flat(cnt_flat),
    .eff_addr(eff_addr)
);

// File: tb/dmac4_core_bench.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a bench-side model of the requirements.
module dmac4_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pg_wr = 1'b0;
    logic [1:0]  pg_sel = '0;
    logic [3:0]  dreq = '0, step = '0;
    logic [3:0]  tc_pulse, cascade, chan_mask;
    logic [95:0] eff_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Bench model
    logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
    logic [7:0]  m_pg[4];
    logic [3:0]  m_auto, m_decr, m_casc, m_mask, m_tc, m_soft;
    logic        m_off;

    always #4 clk = ~clk;

    dmac4_core u_dmac4_core (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pg_wr(pg_wr), .pg_sel(pg_sel), .dreq(dreq), .step(step),
        .tc_pulse(tc_pulse), .cascade(cascade), .chan_mask(chan_mask),
        .eff_addr(eff_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] nxt_addr(input int ch);
        return m_decr[ch] ? m_ca[ch] - 16'd1 : m_ca[ch] + 16'd1;
    endfunction

    task automatic set_reg(input int ch, input bit cnt, input logic [15:0] v);
        wr(4'hC, 8'h00);
        wr(4'(2*ch + int'(cnt)), v[7:0]);
        wr(4'(2*ch + int'(cnt)), v[15:8]);
        if (cnt) begin m_bc[ch] = v; m_cc[ch] = v; end
        else     begin m_ba[ch] = v; m_ca[ch] = v; end
    endtask

    task automatic set_mode(input logic [7:0] b);
        int ch = int'(b[1:0]);
        wr(4'hB, b);
        m_auto[ch] = b[4]; m_decr[ch] = b[5]; m_casc[ch] = (b[7:6] == 2'b11);
    endtask

    task automatic set_mask(input int ch, input bit m);
        wr(4'hA, {5'd0, m, 2'(ch)});
        m_mask[ch] = m;
    endtask

    task automatic set_page(input int ch, input logic [7:0] v);
        @(negedge clk); pg_wr = 1'b1; pg_sel = 2'(ch); bus_wdata = v;
        @(negedge clk); pg_wr = 1'b0;
        m_pg[ch] = v;
    endtask

    task automatic do_step(input int ch);
        bit act;
        @(negedge clk); step[ch] = 1'b1;
        act = !m_mask[ch] && !m_casc[ch] && !m_off;
        #1 chk("R6 tc_pulse", 32'(tc_pulse[ch]), 32'(act && m_cc[ch] == 16'h0));
        @(negedge clk); step = '0;
        if (act) begin
            if (m_cc[ch] == 16'h0) begin
                m_tc[ch] = 1'b1; m_soft[ch] = 1'b0;
                if (m_auto[ch]) begin m_ca[ch] = m_ba[ch]; m_cc[ch] = m_bc[ch]; end
                else begin m_ca[ch] = nxt_addr(ch); m_cc[ch] = 16'hFFFF; m_mask[ch] = 1'b1; end
            end else begin
                m_ca[ch] = nxt_addr(ch); m_cc[ch] = m_cc[ch] - 16'd1;
            end
        end
    endtask

    task automatic check_chan(input int ch, input string tag);
        logic [7:0] lo, hi;
        wr(4'hC, 8'h00);
        rd(4'(2*ch), lo); rd(4'(2*ch), hi);
        chk({tag, " addr"}, {16'd0, hi, lo}, {16'd0, m_ca[ch]});
        rd(4'(2*ch+1), lo); rd(4'(2*ch+1), hi);
        chk({tag, " count"}, {16'd0, hi, lo}, {16'd0, m_cc[ch]});
        chk({tag, " eff_addr R12"}, {8'd0, eff_addr[ch*24 +: 24]}, {8'd0, m_pg[ch], m_ca[ch]});
        chk({tag, " mask R4"}, 32'(chan_mask[ch]), 32'(m_mask[ch]));
    endtask

    task automatic check_status(input string tag);
        logic [7:0] s;
        rd(4'h8, s);
        chk(tag, 32'(s), 32'({dreq | m_soft, m_tc}));
        m_tc = '0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_pg[i] = 0;
        end
        m_auto = 0; m_decr = 0; m_casc = 0; m_mask = 4'hF; m_tc = 0; m_soft = 0; m_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 masks after reset", 32'(chan_mask), 32'hF);
        check_status("R1 status after reset");
        for (int i = 0; i < 4; i++) check_chan(i, "R1 regs after reset");

        // R2: pointer order and reset of the pointer
        wr(4'hC, 0); wr(4'h2, 8'hAA); wr(4'hC, 0); wr(4'h2, 8'hBB); wr(4'h2, 8'hCC);
        m_ba[1] = 16'hCCBB; m_ca[1] = 16'hCCBB;
        check_chan(1, "R2 pointer clear");

        // R5/R6: three transfers on channel 1, no reload
        set_reg(1, 1, 16'd2); set_mode(8'h45); set_mask(1, 0);
        for (int k = 0; k < 3; k++) do_step(1);
        check_chan(1, "R6 tc without reload");
        do_step(1);
        check_chan(1, "R10 step on masked channel");
        check_status("R6 R8 tc flag");
        check_status("R8 flag cleared by read");

        // R7: reload on channel 2
        set_reg(2, 0, 16'h1000); set_reg(2, 1, 16'd1); set_mode(8'h56); set_mask(2, 0);
        do_step(2); do_step(2);
        check_chan(2, "R7 reload");

        // R3/R5: decrement on channel 3
        set_reg(3, 0, 16'h0001); set_reg(3, 1, 16'd5); set_mode(8'h67); set_mask(3, 0);
        do_step(3); do_step(3);
        check_chan(3, "R5 decrement");

        // R12: page stays on 16-bit wrap
        set_mode(8'h44); set_reg(0, 0, 16'hFFFF); set_reg(0, 1, 16'd9);
        set_page(0, 8'h12); set_mask(0, 0);
        do_step(0);
        check_chan(0, "R12 page wrap");

        // R3/R10: cascade blocks steps
        set_mode(8'hC0);
        chk("R3 cascade output", 32'(cascade), 32'h1);
        do_step(0);
        check_chan(0, "R10 cascade step");
        set_mode(8'h44);

        // R10: command disable
        wr(4'h8, 8'h04); m_off = 1;
        do_step(0);
        check_chan(0, "R10 command disable");
        wr(4'h8, 8'h00); m_off = 0;

        // R9/R8: software request and dreq
        wr(4'h9, 8'h05); m_soft[1] = 1;
        dreq = 4'b1000;
        check_status("R9 R8 request bits");
        wr(4'h9, 8'h01); m_soft[1] = 0; dreq = 0;
        check_status("R9 request cleared");

        // R4: all-mask writes
        wr(4'hF, 8'h0A); m_mask = 4'hA;
        chk("R4 mask all", 32'(chan_mask), 32'hA);
        wr(4'hE, 8'h00); m_mask = 4'h0;
        chk("R4 clear masks", 32'(chan_mask), 32'h0);

        // R11: master clear
        wr(4'h9, 8'h06); m_soft[2] = 1;
        wr(4'h8, 8'h04);
        wr(4'hD, 8'h00); m_mask = 4'hF; m_soft = 0; m_tc = 0; m_off = 0;
        chk("R11 masks set", 32'(chan_mask), 32'hF);
        rd(4'hD, b);
        chk("R11 read of 0x0D", 32'(b), 32'h0);
        check_status("R11 status cleared");
        set_mask(0, 0);
        do_step(0);
        check_chan(0, "R11 command bit cleared");

        // Random traffic
        for (int it = 0; it < 600; it++) begin
            int ch = int'($urandom % 4);
            int op = int'($urandom % 12);
            case (op)
                0: begin set_reg(ch, 1, 16'($urandom % 4)); set_reg(ch, 0, 16'($urandom)); end
                1: begin
                    case ($urandom % 5)
                        0: b = 8'h44; 1: b = 8'h48; 2: b = 8'h54; 3: b = 8'h64; default: b = 8'h74;
                    endcase
                    set_mode(b | 8'(ch));
                end
                2: set_mask(ch, 0);
                3: check_chan(ch, "R5 R6 R7 random");
                4: check_status("R8 random status");
                5: set_page(ch, 8'($urandom));
                default: do_step(ch);
            endcase
        end
        for (int i = 0; i < 4; i++) check_chan(i, "R5 R6 R7 final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule